// File: doc/BRIEF.md
# Disk Controller Interrupt Status Tracker

This block holds the interrupt state of a floppy-style disk controller. It answers the query that asks why the interrupt line is up. Event pulses come from the rest of the controller. One arrives when a read or write class command enters its result phase. One arrives when a seek or recalibrate finishes, carrying the drive number, a normal or abnormal flag and the final cylinder. One arrives when the execution phase needs a data byte in non-DMA mode. One arrives when the controller leaves power-down.

Seek and recalibrate have no result phase of their own. Each completion is therefore parked in a per-drive slot, and that drive is reported busy until a sense query retires it. A sense strobe yields a two-byte answer one cycle later: status register 0 followed by the present cylinder number. Completions are retired one per query, the lowest drive number first. When no completion is waiting, a pending result-phase or data-request event is reported as a polling cause. When nothing at all is pending, the answer is the invalid-command code.

Top module: `fdc_irq_tracker`

## Requirements
- R1: One cycle after a pulse on `result_phase_i` or `ndma_req_i`, `irq_o` is 1.
- R2: One cycle after a pulse on `seek_done_i`, `irq_o` is 1 and `busy_o[seek_drive_i]` is 1, and that bit stays 1 until a query retires the completion.
- R3: A strobe on `sense_i` produces `rsp_valid_o` = 1 for exactly the next cycle, with `rsp_st0_o` and `rsp_pcn_o` valid in that cycle.
- R4: A retired completion reports status byte fields IC in bits 7:6 (00 normal, 01 abnormal), SE in bit 5 = 1, bits 4:2 = 0 and the drive number in bits 1:0, so normal gives 20h+drive and abnormal gives 60h+drive. The cylinder byte is the cylinder given with that completion.
- R5: With several completions pending, each query retires only one of them, always the lowest-numbered pending drive, and clears only that drive's busy bit.
- R6: With no completion pending but a result-phase or data-request event pending, a query returns status C0h (IC=11, SE=0) with cylinder 0 and clears that event.
- R7: A query with nothing pending returns status 80h and cylinder 0.
- R8: Bit 2 (head address) of every returned status byte is 0.
- R9: After a query, `irq_o` is 0 only if no completion and no other event remains pending; otherwise it stays 1.
- R10: One cycle after a pulse on `pd_exit_i`, `irq_o` is 0 and `busy_o` is all zero, and a following query returns 80h. Stored cylinders are cleared too.
- R11: After reset, `irq_o`, `busy_o` and `rsp_valid_o` are 0.
- R12: A second completion on a drive that is still pending replaces its cylinder and abnormal flag. A completion on the drive that a query retires in the same cycle stays pending with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| result_phase_i | input | 1 | Pulse: a read/write class command entered its result phase |
| ndma_req_i | input | 1 | Pulse: execution phase needs a byte transfer in non-DMA mode |
| seek_done_i | input | 1 | Pulse: a seek, relative seek or recalibrate finished |
| seek_drive_i | input | DRV_W | Drive number of the finished seek |
| seek_abnormal_i | input | 1 | The finished seek ended abnormally |
| seek_cyl_i | input | CYL_W | Cylinder the head ended on |
| pd_exit_i | input | 1 | Pulse: controller leaves power-down |
| sense_i | input | 1 | Sense-interrupt-status query strobe |
| irq_o | output | 1 | Interrupt line |
| busy_o | output | NUM_DRV | Per-drive busy (completion not yet retired) |
| rsp_valid_o | output | 1 | Response bytes valid this cycle |
| rsp_st0_o | output | 8 | Status register 0 of the response |
| rsp_pcn_o | output | CYL_W | Present cylinder number of the response |

## Verification
Directed runs cover an empty query, lone result-phase and data-request events, and a mix of normal and abnormal completions on out-of-order drives. The mix separates lowest-first retiring from arrival order and shows the completion cause taking priority over the polling cause. Back-to-back completions on one drive, and a completion landing in the same cycle as the query that retires that drive, show which write wins. A long run of random overlapping pulses, power-down exits included, is compared each cycle against a behavioural model. That run exposes ordering and interrupt-release errors that the fixed patterns miss.

// File: rtl/fdc_irq_pkg.sv
package fdc_irq_pkg;

    // Cause codes carried in bits 7:6 of status register 0
    localparam logic [1:0] IC_NORMAL  = 2'b00;
    localparam logic [1:0] IC_ABNORM  = 2'b01;
    localparam logic [1:0] IC_INVALID = 2'b10;
    localparam logic [1:0] IC_POLL    = 2'b11;

    typedef struct packed {
        logic [1:0] ic;
        logic       se;
        logic       ec;
        logic       nr;
        logic       head;
        logic [1:0] ds;
    } st0_t;

    function automatic logic [7:0] pack_st0(input logic [1:0] ic,
                                            input logic       se,
                                            input logic [1:0] ds);
        st0_t s;
        s.ic   = ic;
        s.se   = se;
        s.ec   = 1'b0;
        s.nr   = 1'b0;
        s.head = 1'b0;
        s.ds   = ds;
        return s;
    endfunction

endpackage

// File: rtl/fdc_drive_slot.sv
module fdc_drive_slot #(
    parameter int CYL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             set_i,
    input  logic             abn_i,
    input  logic [CYL_W-1:0] cyl_i,
    input  logic             retire_i,
    output logic             pend_o,
    output logic             abn_o,
    output logic [CYL_W-1:0] cyl_o
);

    typedef struct packed {
        logic             pend;
        logic             abn;
        logic [CYL_W-1:0] cyl;
    } slot_t;

    slot_t slot_d, slot_q;

    // Priority: power-down clear, then a new completion, then retirement
    always_comb begin
        slot_d = slot_q;
        if (clear_i) begin
            slot_d = '0;
        end else if (set_i) begin
            slot_d.pend = 1'b1;
            slot_d.abn  = abn_i;
            slot_d.cyl  = cyl_i;
        end else if (retire_i) begin
            slot_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign pend_o = slot_q.pend;
    assign abn_o  = slot_q.abn;
    assign cyl_o  = slot_q.cyl;

endmodule

// File: rtl/fdc_low_pick.sv
module fdc_low_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     grant_o
);

    always_comb begin
        idx_o   = '0;
        grant_o = '0;
        any_o   = |req_i;
        // Walk downward so the lowest requester is the last one written
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o   = IDX_W'(i);
                grant_o = N'(1) << i;
            end
        end
    end

endmodule

// File: rtl/fdc_sense_fmt.sv
module fdc_sense_fmt #(
    parameter int IDX_W = 2,
    parameter int CYL_W = 8
) (
    input  logic             drv_any_i,
    input  logic [IDX_W-1:0] drv_idx_i,
    input  logic             drv_abn_i,
    input  logic [CYL_W-1:0] drv_cyl_i,
    input  logic             gen_pend_i,
    output logic [7:0]       st0_o,
    output logic [CYL_W-1:0] pcn_o
);
    import fdc_irq_pkg::*;

    always_comb begin
        if (drv_any_i) begin
            st0_o = pack_st0(drv_abn_i ? IC_ABNORM : IC_NORMAL, 1'b1, 2'(drv_idx_i));
            pcn_o = drv_cyl_i;
        end else if (gen_pend_i) begin
            st0_o = pack_st0(IC_POLL, 1'b0, 2'b00);
            pcn_o = '0;
        end else begin
            st0_o = pack_st0(IC_INVALID, 1'b0, 2'b00);
            pcn_o = '0;
        end
    end

endmodule

// File: rtl/fdc_irq_tracker.sv
module fdc_irq_tracker #(
    parameter int NUM_DRV = 4,
    parameter int CYL_W   = 8,
    localparam int DRV_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               result_phase_i,
    input  logic               ndma_req_i,
    input  logic               seek_done_i,
    input  logic [DRV_W-1:0]   seek_drive_i,
    input  logic               seek_abnormal_i,
    input  logic [CYL_W-1:0]   seek_cyl_i,
    input  logic               pd_exit_i,
    input  logic               sense_i,
    output logic               irq_o,
    output logic [NUM_DRV-1:0] busy_o,
    output logic               rsp_valid_o,
    output logic [7:0]         rsp_st0_o,
    output logic [CYL_W-1:0]   rsp_pcn_o
);

    typedef struct packed {
        logic             gen;
        logic             rsp_valid;
        logic [7:0]       rsp_st0;
        logic [CYL_W-1:0] rsp_pcn;
    } trk_t;

    trk_t trk_d, trk_q;

    logic [NUM_DRV-1:0] pend_v;
    logic [NUM_DRV-1:0] abn_v;
    logic [NUM_DRV-1:0] grant_v;
    logic [NUM_DRV-1:0] set_v;
    logic [NUM_DRV-1:0] retire_v;
    logic [CYL_W-1:0]   cyl_a [NUM_DRV];
    logic               drv_any;
    logic [DRV_W-1:0]   drv_idx;
    logic [7:0]         st0_n;
    logic [CYL_W-1:0]   pcn_n;

    // One completion slot per drive
    for (genvar g = 0; g < NUM_DRV; g++) begin : g_slot
        assign set_v[g]    = seek_done_i && (seek_drive_i == DRV_W'(g));
        assign retire_v[g] = sense_i && grant_v[g];

        fdc_drive_slot #(.CYL_W(CYL_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (pd_exit_i),
            .set_i    (set_v[g]),
            .abn_i    (seek_abnormal_i),
            .cyl_i    (seek_cyl_i),
            .retire_i (retire_v[g]),
            .pend_o   (pend_v[g]),
            .abn_o    (abn_v[g]),
            .cyl_o    (cyl_a[g])
        );
    end

    fdc_low_pick #(.N(NUM_DRV), .IDX_W(DRV_W)) u_pick (
        .req_i   (pend_v),
        .any_o   (drv_any),
        .idx_o   (drv_idx),
        .grant_o (grant_v)
    );

    fdc_sense_fmt #(.IDX_W(DRV_W), .CYL_W(CYL_W)) u_fmt (
        .drv_any_i  (drv_any),
        .drv_idx_i  (drv_idx),
        .drv_abn_i  (abn_v[drv_idx]),
        .drv_cyl_i  (cyl_a[drv_idx]),
        .gen_pend_i (trk_q.gen),
        .st0_o      (st0_n),
        .pcn_o      (pcn_n)
    );

    always_comb begin
        trk_d           = trk_q;
        trk_d.rsp_valid = sense_i;
        trk_d.rsp_st0   = sense_i ? st0_n : 8'h00;
        trk_d.rsp_pcn   = sense_i ? pcn_n : '0;
        // The polling cause is consumed only when no completion outranks it
        if (sense_i && !drv_any) begin
            trk_d.gen = 1'b0;
        end
        if (result_phase_i || ndma_req_i) begin
            trk_d.gen = 1'b1;
        end
        if (pd_exit_i) begin
            trk_d.gen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign irq_o       = (|pend_v) || trk_q.gen;
    assign busy_o      = pend_v;
    assign rsp_valid_o = trk_q.rsp_valid;
    assign rsp_st0_o   = trk_q.rsp_st0;
    assign rsp_pcn_o   = trk_q.rsp_pcn;

endmodule

// File: rtl/fdc_irq_tracker_chk.sv
module fdc_irq_tracker_chk #(
    parameter int NUM_DRV = 4,
    parameter int CYL_W   = 8,
    localparam int DRV_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               result_phase_i,
    input logic               ndma_req_i,
    input logic               seek_done_i,
    input logic [DRV_W-1:0]   seek_drive_i,
    input logic               pd_exit_i,
    input logic               sense_i,
    input logic               irq_o,
    input logic [NUM_DRV-1:0] busy_o,
    input logic               rsp_valid_o,
    input logic [7:0]         rsp_st0_o
);

    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (result_phase_i || ndma_req_i) && !pd_exit_i |=> irq_o); // R1

    AST_SEEK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seek_done_i && !pd_exit_i |=> irq_o && busy_o[$past(seek_drive_i)]); // R2

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        sense_i |=> rsp_valid_o); // R3

    AST_RSP_ONLY_AFTER_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(sense_i)); // R3

    AST_SINGLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        sense_i && !seek_done_i && !pd_exit_i |=>
            $countones($past(busy_o) & ~busy_o) <= 1); // R5

    AST_EMPTY_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        sense_i && !irq_o |=> rsp_st0_o == 8'h80); // R7

    AST_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !rsp_st0_o[2]); // R8

    AST_PD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pd_exit_i |=> !irq_o && busy_o == '0); // R10

endmodule

bind fdc_irq_tracker fdc_irq_tracker_chk #(.NUM_DRV(NUM_DRV), .CYL_W(CYL_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .result_phase_i (result_phase_i),
    .ndma_req_i     (ndma_req_i),
    .seek_done_i    (seek_done_i),
    .seek_drive_i   (seek_drive_i),
    .pd_exit_i      (pd_exit_i),
    .sense_i        (sense_i),
    .irq_o          (irq_o),
    .busy_o         (busy_o),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_st0_o      (rsp_st0_o)
);

// File: tb/tb_fdc_irq_tracker.sv
`timescale 1ns/1ps
module tb_fdc_irq_tracker;

    localparam int ND = 4;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rp = 1'b0, ndma = 1'b0, sdone = 1'b0, sabn = 1'b0, pd = 1'b0, sense = 1'b0;
    logic [1:0]    sdrv = '0;
    logic [CW-1:0] scyl = '0;
    logic          irq, rvalid;
    logic [ND-1:0] busy;
    logic [7:0]    rst0;
    logic [CW-1:0] rpcn;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    fdc_irq_tracker #(.NUM_DRV(ND), .CYL_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .result_phase_i(rp), .ndma_req_i(ndma),
        .seek_done_i(sdone), .seek_drive_i(sdrv), .seek_abnormal_i(sabn),
        .seek_cyl_i(scyl), .pd_exit_i(pd), .sense_i(sense),
        .irq_o(irq), .busy_o(busy), .rsp_valid_o(rvalid),
        .rsp_st0_o(rst0), .rsp_pcn_o(rpcn)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_pend [ND];
    int m_abn  [ND];
    int m_cyl  [ND];
    int m_gen;
    int m_valid, m_st0, m_pcn;

    always @(posedge clk) begin
        int f;
        if (!rst_n) begin
            for (int i = 0; i < ND; i++) begin m_pend[i] = 0; m_abn[i] = 0; m_cyl[i] = 0; end
            m_gen = 0; m_valid = 0; m_st0 = 0; m_pcn = 0;
        end else begin
            f = -1;
            for (int i = ND - 1; i >= 0; i--) if (m_pend[i] != 0) f = i;
            m_valid = sense ? 1 : 0;
            if (sense) begin
                if (f >= 0) begin
                    m_st0 = (m_abn[f] != 0 ? 'h60 : 'h20) + f;
                    m_pcn = m_cyl[f];
                    m_pend[f] = 0;
                end else if (m_gen != 0) begin
                    m_st0 = 'hC0; m_pcn = 0; m_gen = 0;
                end else begin
                    m_st0 = 'h80; m_pcn = 0;
                end
            end
            if (sdone) begin m_pend[sdrv] = 1; m_abn[sdrv] = int'(sabn); m_cyl[sdrv] = int'(scyl); end
            if (rp || ndma) m_gen = 1;
            if (pd) begin
                for (int i = 0; i < ND; i++) begin m_pend[i] = 0; m_abn[i] = 0; m_cyl[i] = 0; end
                m_gen = 0;
            end
        end
    end

    function automatic int m_irq();
        int r = m_gen;
        for (int i = 0; i < ND; i++) if (m_pend[i] != 0) r = 1;
        return r;
    endfunction

    function automatic int m_busy();
        int r = 0;
        for (int i = 0; i < ND; i++) if (m_pend[i] != 0) r |= (1 << i);
        return r;
    endfunction

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(irq) == m_irq(), "R1/R2/R9 irq", int'(irq), m_irq());
            chk(int'(busy) == m_busy(), "R2/R5/R12 busy", int'(busy), m_busy());
            chk(int'(rvalid) == m_valid, "R3 rsp_valid", int'(rvalid), m_valid);
            if (rvalid) begin
                chk(int'(rst0) == m_st0, "R4/R6/R7 st0", int'(rst0), m_st0);
                chk(int'(rpcn) == m_pcn, "R4 pcn", int'(rpcn), m_pcn);
                chk(rst0[2] == 1'b0, "R8 head bit", int'(rst0[2]), 0);
            end
        end
    end

    task automatic seek(input int d, input bit abn, input int cyl);
        @(negedge clk);
        sdone = 1'b1; sdrv = 2'(d); sabn = abn; scyl = CW'(cyl);
        @(negedge clk);
        sdone = 1'b0;
    endtask

    task automatic pulse_rp();
        @(negedge clk); rp = 1'b1; @(negedge clk); rp = 1'b0;
    endtask

    task automatic pulse_ndma();
        @(negedge clk); ndma = 1'b1; @(negedge clk); ndma = 1'b0;
    endtask

    task automatic query(input int st0, input int pcn, input string tag);
        @(negedge clk); sense = 1'b1;
        @(negedge clk); sense = 1'b0;
        chk(rvalid == 1'b1, {tag, " valid"}, int'(rvalid), 1);
        chk(int'(rst0) == st0, {tag, " st0"}, int'(rst0), st0);
        chk(int'(rpcn) == pcn, {tag, " pcn"}, int'(rpcn), pcn);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R3 watchdog expired act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(irq == 1'b0, "R11 irq", int'(irq), 0);
        chk(busy == '0, "R11 busy", int'(busy), 0);
        chk(rvalid == 1'b0, "R11 valid", int'(rvalid), 0);

        query('h80, 0, "R7 empty");

        pulse_rp();
        chk(irq == 1'b1, "R1 irq after result phase", int'(irq), 1);
        query('hC0, 0, "R6 polling");
        chk(irq == 1'b0, "R9 irq released", int'(irq), 0);

        pulse_ndma();
        chk(irq == 1'b1, "R1 irq after data request", int'(irq), 1);
        query('hC0, 0, "R6 polling ndma");

        seek(2, 1'b0, 40);
        chk(busy == 4'b0100, "R2 busy drive 2", int'(busy), 'b0100);
        seek(0, 1'b1, 5);
        seek(3, 1'b0, 77);
        pulse_rp();
        query('h60, 5, "R4 R5 drive0 abnormal");
        chk(irq == 1'b1, "R9 irq held", int'(irq), 1);
        chk(busy == 4'b1100, "R5 one retired", int'(busy), 'b1100);
        query('h22, 40, "R5 drive2");
        query('h23, 77, "R5 drive3");
        query('hC0, 0, "R6 polling after drives");
        chk(irq == 1'b0, "R9 irq low", int'(irq), 0);
        query('h80, 0, "R7 empty again");

        seek(1, 1'b0, 10);
        seek(1, 1'b1, 12);
        query('h61, 12, "R12 replaced");
        seek(1, 1'b0, 3);
        @(negedge clk);
        sense = 1'b1; sdone = 1'b1; sdrv = 2'd1; sabn = 1'b0; scyl = 8'd9;
        @(negedge clk);
        sense = 1'b0; sdone = 1'b0;
        chk(int'(rst0) == 'h21 && int'(rpcn) == 3, "R12 same-cycle retire", int'(rst0), 'h21);
        chk(busy[1] == 1'b1, "R12 still busy", int'(busy[1]), 1);
        query('h21, 9, "R12 new values");

        seek(2, 1'b1, 50);
        pulse_rp();
        @(negedge clk); pd = 1'b1; @(negedge clk); pd = 1'b0;
        chk(irq == 1'b0 && busy == '0, "R10 power-down clear", int'(busy), 0);
        query('h80, 0, "R10 empty after power-down");

        // Random overlapping stimulus, checked against the model each cycle
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            sense = ($urandom_range(0, 3) == 0);
            rp    = ($urandom_range(0, 9) == 0);
            ndma  = ($urandom_range(0, 11) == 0);
            sdone = ($urandom_range(0, 4) == 0);
            sdrv  = 2'($urandom_range(0, 3));
            sabn  = 1'($urandom_range(0, 1));
            scyl  = CW'($urandom_range(0, 255));
            pd    = ($urandom_range(0, 79) == 0);
        end
        @(negedge clk);
        sense = 1'b0; rp = 1'b0; ndma = 1'b0; sdone = 1'b0; pd = 1'b0;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule